// File: doc/BRIEF.md
# Write-Protected Retained Scratch Register Bank

This block is a small register bank for an always-on, slow-clocked part of a chip. It gives software three 32-bit scratch words. Software can use them to leave markers that must outlive a reboot, such as a boot counter or a flag that shows configuration has been done. The words have no effect on any other logic. They are cleared only by the power-on reset of the retained domain or by a software reset issued through the bank's own control register. A bus-side reset, whether soft or hard, leaves them as they were.

Every write except a key write is blocked until software has unlocked the bank. To unlock it, software writes the first key value to one key register and then the second key value to another. Writing a wrong value to either key register locks the bank again.

The software reset has three effects: it zeroes the bank, locks it, and raises `busy`. `busy` stays high until three rising edges of the slow reference clock have been seen through a synchronizer. While `busy` is high, the bank ignores every access, and reads return zero.

Top module: `aon_scratch_bank`

## Requirements
- R1: While unlocked, a write to byte offset 0x60, 0x64 or 0x68 stores the 32-bit data in scratch word 0, 1 or 2, and a read of that offset returns it.
- R2: While locked, writes to any offset other than the two key offsets are ignored. This includes the control offset, so a locked software-reset write does not raise `busy`.
- R3: The bank unlocks only when 0x83E70B13 is written at offset 0x6C and then 0x95A4F1E0 is written at offset 0x70. The second key alone does not unlock. Neither does the second key followed by the first.
- R4: Writing any value other than its key to offset 0x6C or 0x70 returns the bank to the locked state.
- R5: While unlocked, a write to offset 0x54 with bit 5 set has three effects: all scratch words clear to 0x00000000, the bank locks, and both keys must be written again before a further write takes effect.
- R6: `busy` rises on the cycle after an accepted software reset. It falls once three rising edges of `slow_clk` have been seen through a two-flop synchronizer. While `busy` is high, writes are ignored (key writes included) and reads return zero.
- R7: A bus-side reset (`rst_n` low) leaves the scratch contents unchanged.
- R8: Power-on reset (`por_n` low) clears the scratch words, locks the bank and clears `busy`.
- R9: Unmapped or unaligned offsets read as zero and ignore writes. The control offset 0x54 reads as zero, because the reset bit clears itself.
- R10: `rdata` carries the read value on the cycle after `rd_en` is sampled. On any cycle after which no read was sampled, `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus-side reset, active low; scratch state is kept |
| por_n | input | 1 | Power-on reset of the retained domain, active low |
| slow_clk | input | 1 | Slow reference clock, asynchronous to `clk` |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| busy | output | 1 | Software reset in progress; the bank ignores access |

## Verification
The bench targets the key ordering. A design that latched each key on its own would unlock after the keys were written in reverse order. A design that did not clear progress on a wrong key would stay open after a bad second-key write.

During the software-reset window, the bench writes both keys and then a scratch word. A design that accepted accesses while `busy` was high would come out of the window unlocked and holding that word.

The bench times `busy` against the slow clock. A counter that ran on bus cycles, or that stopped one edge short, would fall outside the expected window.

The bench also pulses only the bus reset and checks that the retained words come back intact. A design that put the scratch words on the bus reset would read zeros there.

// File: rtl/aon_scratch_bank.sv
module aon_scratch_bank #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int N_SCRATCH   = 3,
  parameter int SWRST_BIT   = 5,
  parameter int SLOW_EDGES  = 3,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] SCR_BASE = 'h60,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 'h54,
  parameter logic [ADDR_W-1:0] KEYA_OFS = 'h6C,
  parameter logic [ADDR_W-1:0] KEYB_OFS = 'h70,
  parameter logic [DATA_W-1:0] KEYA_VAL = 'h83E70B13,
  parameter logic [DATA_W-1:0] KEYB_VAL = 'h95A4F1E0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              slow_clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  output logic              busy
);
  localparam int CNT_W = $clog2(SLOW_EDGES + 1);

  typedef enum logic [1:0] {LK_SHUT, LK_HALF, LK_OPEN} lock_e;

  lock_e                              lk;
  logic                               unlocked;
  logic [N_SCRATCH-1:0][DATA_W-1:0]   scr;
  logic [N_SCRATCH-1:0]               scr_hit;
  logic [SYNC_STAGES-1:0]             sync_q;
  logic                               slow_prev;
  logic [CNT_W-1:0]                   edge_cnt;
  logic [DATA_W-1:0]                  rd_val;

  wire bus_rst_n = rst_n & por_n;
  wire wr_ok     = wr_en & ~busy;
  wire ctrl_hit  = (addr == CTRL_OFS);
  wire keya_hit  = (addr == KEYA_OFS);
  wire keyb_hit  = (addr == KEYB_OFS);
  wire swrst_go  = wr_ok & ctrl_hit & unlocked & wdata[SWRST_BIT];
  wire slow_rise = sync_q[SYNC_STAGES-1] & ~slow_prev;

  assign unlocked = (lk == LK_OPEN);

  for (genvar i = 0; i < N_SCRATCH; i++) begin : g_dec
    assign scr_hit[i] = (addr == SCR_BASE + ADDR_W'(4 * i));
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      lk <= LK_SHUT;
    else if (swrst_go)
      lk <= LK_SHUT;
    else if (wr_ok && keya_hit)
      lk <= (wdata != KEYA_VAL) ? LK_SHUT : (lk == LK_OPEN) ? LK_OPEN : LK_HALF;
    else if (wr_ok && keyb_hit) begin
      if (wdata != KEYB_VAL)  lk <= LK_SHUT;
      else if (lk == LK_HALF) lk <= LK_OPEN;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      scr <= '0;
    else if (swrst_go)
      scr <= '0;
    else if (wr_ok && unlocked)
      for (int i = 0; i < N_SCRATCH; i++)
        if (scr_hit[i]) scr[i] <= wdata;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sync_q    <= '0;
      slow_prev <= 1'b0;
      busy      <= 1'b0;
      edge_cnt  <= '0;
    end else begin
      sync_q    <= {sync_q[SYNC_STAGES-2:0], slow_clk};
      slow_prev <= sync_q[SYNC_STAGES-1];
      if (swrst_go) begin
        busy     <= 1'b1;
        edge_cnt <= '0;
      end else if (busy && slow_rise) begin
        if (edge_cnt == CNT_W'(SLOW_EDGES - 1)) begin
          busy     <= 1'b0;
          edge_cnt <= '0;
        end else begin
          edge_cnt <= edge_cnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < N_SCRATCH; i++)
      if (scr_hit[i]) rd_val = scr[i];
  end

  always_ff @(posedge clk or negedge bus_rst_n) begin
    if (!bus_rst_n) rdata <= '0;
    else            rdata <= (rd_en && !busy) ? rd_val : '0;
  end
endmodule

module aon_scratch_bank_chk #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int N_SCRATCH = 3,
  parameter int SWRST_BIT = 5,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 'h54,
  parameter logic [ADDR_W-1:0] KEYB_OFS = 'h70,
  parameter logic [DATA_W-1:0] KEYB_VAL = 'h95A4F1E0
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             por_n,
  input logic [ADDR_W-1:0]                addr,
  input logic [DATA_W-1:0]                wdata,
  input logic                             wr_en,
  input logic                             rd_en,
  input logic [DATA_W-1:0]                rdata,
  input logic                             busy,
  input logic                             unlocked,
  input logic [N_SCRATCH-1:0][DATA_W-1:0] scr
);
  a_r2_locked_hold: assert property (@(posedge clk) disable iff (!por_n)
    !unlocked |=> $stable(scr));

  a_r3_unlock_by_keyb: assert property (@(posedge clk) disable iff (!por_n)
    $rose(unlocked) |-> $past(wr_en && addr == KEYB_OFS && wdata == KEYB_VAL));

  a_r5_swrst_clears: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && !busy && unlocked && addr == CTRL_OFS && wdata[SWRST_BIT])
      |=> (busy && !unlocked && scr == '0));

  a_r6_busy_hold: assert property (@(posedge clk) disable iff (!por_n)
    busy |=> $stable(scr));

  a_r6_busy_locked: assert property (@(posedge clk) disable iff (!por_n)
    busy |-> !unlocked);

  a_r6_busy_rd_zero: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (busy && rd_en) |=> rdata == '0);

  a_r7_bus_rst_keeps: assert property (@(posedge clk) disable iff (!por_n)
    !rst_n |=> $stable(scr));

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    !rd_en |=> rdata == '0);
endmodule

bind aon_scratch_bank aon_scratch_bank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_SCRATCH(N_SCRATCH), .SWRST_BIT(SWRST_BIT),
  .CTRL_OFS(CTRL_OFS), .KEYB_OFS(KEYB_OFS), .KEYB_VAL(KEYB_VAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .por_n(por_n), .addr(addr), .wdata(wdata),
  .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .busy(busy),
  .unlocked(unlocked), .scr(scr)
);

// File: tb/aon_scratch_bank_tb.sv
module aon_scratch_bank_tb;
  localparam logic [31:0] KA = 32'h83E70B13;
  localparam logic [31:0] KB = 32'h95A4F1E0;

  logic        clk = 0, rst_n = 0, por_n = 0, slow_clk = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wr_en = 0, rd_en = 0;
  logic [31:0] rdata;
  logic        busy;

  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        pend = 0, mon_on = 0;

  aon_scratch_bank u_dut (.clk(clk), .rst_n(rst_n), .por_n(por_n), .slow_clk(slow_clk),
    .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .busy(busy));

  always #4 clk = ~clk;
  always #80 slow_clk = ~slow_clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    addr = a; rd_en = 1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 0;
    @(negedge clk);
  endtask

  task automatic unlock();
    wr(8'h6C, KA);
    wr(8'h70, KB);
  endtask

  always @(posedge clk) pend <= rd_en;

  always @(negedge clk) begin
    if (mon_on && rst_n && por_n) begin
      if (pend) begin
        if (exp_q.size() == 0) check("R10 unexpected read", rdata, 32'h0);
        else check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end else if (rdata !== 32'h0) begin
        check("R10 idle rdata", rdata, 32'h0);
      end
    end
  end

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cyc;
    repeat (5) @(negedge clk);
    por_n = 1; rst_n = 1; mon_on = 1;
    @(negedge clk);
    check("R8 busy after power-on", {31'h0, busy}, 32'h0);
    rd(8'h60, 0, "R8 scr0 after power-on");
    rd(8'h64, 0, "R8 scr1 after power-on");
    rd(8'h68, 0, "R8 scr2 after power-on");

    wr(8'h60, 32'hA5A5_0001);
    rd(8'h60, 0, "R2 locked scratch write ignored");
    wr(8'h54, 32'h20);
    @(negedge clk);
    check("R2 locked swrst ignored", {31'h0, busy}, 32'h0);

    wr(8'h70, KB);
    wr(8'h64, 32'h1111_2222);
    rd(8'h64, 0, "R3 second key alone");
    wr(8'h6C, KA);
    wr(8'h64, 32'h3333_4444);
    rd(8'h64, 0, "R3 keys in reverse order");
    wr(8'h70, KB);
    wr(8'h60, 32'hDEAD_BEEF);
    wr(8'h64, 32'h0123_4567);
    wr(8'h68, 32'hFFFF_0000);
    rd(8'h60, 32'hDEAD_BEEF, "R1 scr0");
    rd(8'h64, 32'h0123_4567, "R1 scr1");
    rd(8'h68, 32'hFFFF_0000, "R1 scr2");
    wr(8'h68, 32'h0000_FFFF);
    rd(8'h68, 32'h0000_FFFF, "R1 scr2 rewrite");

    wr(8'h5C, 32'hFFFF_FFFF);
    rd(8'h5C, 0, "R9 unmapped offset");
    rd(8'h62, 0, "R9 unaligned offset");
    rd(8'h54, 0, "R9 control reads zero");
    rd(8'h60, 32'hDEAD_BEEF, "R9 scr0 untouched");

    wr(8'h70, 32'h1234_5678);
    wr(8'h64, 32'hBAD0_BAD0);
    rd(8'h64, 32'h0123_4567, "R4 wrong second key relocks");
    wr(8'h6C, KA);
    wr(8'h6C, 32'h0);
    wr(8'h70, KB);
    wr(8'h64, 32'hBAD1_BAD1);
    rd(8'h64, 32'h0123_4567, "R4 wrong first key relocks");

    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk); rst_n = 1;
    rd(8'h60, 32'hDEAD_BEEF, "R7 scr0 after bus reset");
    rd(8'h64, 32'h0123_4567, "R7 scr1 after bus reset");
    rd(8'h68, 32'h0000_FFFF, "R7 scr2 after bus reset");

    unlock();
    wr(8'h54, 32'h20);
    cyc = 0;
    check("R6 busy after swrst", {31'h0, busy}, 32'h1);
    wr(8'h6C, KA); wr(8'h70, KB); wr(8'h60, 32'h5555_AAAA);
    cyc = cyc + 6;
    rd(8'h60, 0, "R6 read during busy");
    cyc = cyc + 3;
    while (busy && cyc < 200) begin @(negedge clk); cyc++; end
    check("R6 busy length lower", {31'h0, cyc >= 38}, 32'h1);
    check("R6 busy length upper", {31'h0, cyc <= 66}, 32'h1);
    rd(8'h60, 0, "R5 scr0 cleared");
    rd(8'h64, 0, "R5 scr1 cleared");
    rd(8'h68, 0, "R5 scr2 cleared");
    rd(8'h54, 0, "R9 reset bit self-clears");
    wr(8'h60, 32'h7777_7777);
    rd(8'h60, 0, "R5 relocked, busy writes dropped");
    unlock();
    wr(8'h60, 32'h7777_7777);
    rd(8'h60, 32'h7777_7777, "R5 new unlock works");

    @(negedge clk); por_n = 0;
    repeat (3) @(negedge clk); por_n = 1;
    rd(8'h60, 0, "R8 scr0 after power-on reset");
    wr(8'h60, 32'h9999_9999);
    rd(8'h60, 0, "R8 locked after power-on reset");
    repeat (3) @(negedge clk);
    check("R10 queue drained", exp_q.size(), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule